// File: doc/BRIEF.md
# All-Pairs Round-Based Maximum Finder

This block takes a vector of unsigned values in one cycle and reports the largest of them, together with the position it held in the vector. It does not use a binary tree of two-input maxima. It works in rounds. In each round the surviving values are split into groups. Every pair inside a group is compared in the same cycle, and any value that loses one of those comparisons is marked. The single unmarked value of each group moves to a fixed slot that feeds the next round.

Group sizes follow the growth rule s_k = 2·m_k + 1, where m_1 = 1 and m_{k+1} = m_k·(2·m_k + 1). The sizes are therefore 3, 7, 43 and so on, and each group needs s_k·(s_k − 1)/2 comparators. With 21 inputs, the first round forms seven groups of three. The second round takes the seven winners as one group and produces the overall maximum. Each round ends in a register, so results come out two cycles after the vector is accepted, and a new vector can be accepted every cycle.

When values are equal, the one from the higher original position is the one marked. This gives every group exactly one winner.

Top module: `allpairs_max`

## Requirements
- R1: When `out_valid` is high, `out_max` equals the largest of the 21 unsigned 16-bit values of the accepted vector; value i occupies `in_data[16*i+15:16*i]`.
- R2: When `out_valid` is high, `out_idx` gives the position i (0 to 20) of the value reported in `out_max`.
- R3: When several positions hold the maximum, `out_idx` reports the lowest of those positions.
- R4: `out_valid` is high at the second rising edge after a rising edge at which `in_valid` was high, and low after any edge whose input two edges earlier was not valid; results leave in the order the vectors arrived.
- R5: Vectors presented on consecutive cycles are all accepted, and each one produces its own correct result with no bubble inserted.
- R6: While `rst_n` is low, and during the first two edges after it is released, `out_valid` is low, and no vector accepted before a reset produces a result after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when `in_data` holds a vector to reduce |
| in_data | input | 336 | Flattened vector of 21 unsigned 16-bit values, position 0 in the low bits |
| out_valid | output | 1 | High when `out_max` and `out_idx` hold a result |
| out_max | output | 16 | Largest value of the vector |
| out_idx | output | 5 | Position in the vector of the reported maximum |

## Verification
A comparator with the wrong sense, or a loser mark that is never set, leaves a group with no winner or with two. Either fault shows two cycles later as an `out_max` that is not the largest value, or as an `out_idx` that points to a different value. A fault in index-based tie breaking shows only when equal maxima are present, so the stimulus places equal maxima inside one first-round group and also across two groups. A slip in the valid delay, or in the way reset clears the rounds, shows at once as a strobe one edge early or late, or as a result that leaks across a reset.

// File: rtl/allpairs_max_pkg.sv
package allpairs_max_pkg;

   // Group size used in round rnd (1-based): 2*m+1 with m the sparsity.
   function automatic int grp_size(input int rnd);
      int m;
      m = 1;
      for (int k = 1; k < rnd; k++) begin
         m = m * (2 * m + 1);
      end
      return 2 * m + 1;
   endfunction

   // Comparators needed to cover every pair of a group.
   function automatic int pair_count(input int n);
      return (n * (n - 1)) / 2;
   endfunction

endpackage

// File: rtl/allpairs_max_group.sv
module allpairs_max_group #(
   parameter int GSIZE  = 3,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 5
) (
   input  logic [GSIZE*DATA_W-1:0] grp_val,
   input  logic [GSIZE*IDX_W-1:0]  grp_idx,
   output logic [DATA_W-1:0]       win_val,
   output logic [IDX_W-1:0]        win_idx,
   output logic [GSIZE-1:0]        win_hot
);

   localparam int NCELL = GSIZE * GSIZE;

   if (GSIZE < 2) begin : g_bad_size
      $error("allpairs_max_group: GSIZE must be at least 2");
   end

   // beaten[r*GSIZE+c] set when member r lost its comparison with member c
   logic [NCELL-1:0] beaten;
   logic [GSIZE-1:0] marked;

   for (genvar r = 0; r < GSIZE; r++) begin : g_row
      for (genvar c = 0; c < GSIZE; c++) begin : g_col
         if (r == c) begin : g_diag
            assign beaten[r*GSIZE+c] = 1'b0;
         end else if (r < c) begin : g_cmp
            logic first_wins;
            // one comparator per unordered pair; equal values go to the lower index
            assign first_wins =
               (grp_val[r*DATA_W +: DATA_W] >  grp_val[c*DATA_W +: DATA_W]) ||
               ((grp_val[r*DATA_W +: DATA_W] == grp_val[c*DATA_W +: DATA_W]) &&
                (grp_idx[r*IDX_W +: IDX_W]   <  grp_idx[c*IDX_W +: IDX_W]));
            assign beaten[r*GSIZE+c] = ~first_wins;
            assign beaten[c*GSIZE+r] =  first_wins;
         end
      end
      // marks from all comparisons combine like concurrent writes
      assign marked[r] = |beaten[r*GSIZE +: GSIZE];
   end

   assign win_hot = ~marked;

   // one-hot selection of the unmarked member
   always_comb begin
      win_val = '0;
      win_idx = '0;
      for (int k = 0; k < GSIZE; k++) begin
         win_val = win_val | ({DATA_W{win_hot[k]}} & grp_val[k*DATA_W +: DATA_W]);
         win_idx = win_idx | ({IDX_W{win_hot[k]}}  & grp_idx[k*IDX_W +: IDX_W]);
      end
   end

endmodule

// File: rtl/allpairs_max_round.sv
module allpairs_max_round #(
   parameter int GROUPS = 7,
   parameter int GSIZE  = 3,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           stg_in_valid,
   input  logic [GROUPS*GSIZE*DATA_W-1:0] stg_in_val,
   input  logic [GROUPS*GSIZE*IDX_W-1:0]  stg_in_idx,
   output logic                           stg_out_valid,
   output logic [GROUPS*DATA_W-1:0]       stg_out_val,
   output logic [GROUPS*IDX_W-1:0]        stg_out_idx
);

   localparam int GV_W = GSIZE * DATA_W;
   localparam int GI_W = GSIZE * IDX_W;

   if (GROUPS < 1) begin : g_bad_groups
      $error("allpairs_max_round: GROUPS must be at least 1");
   end

   logic [GROUPS*DATA_W-1:0] nxt_val;
   logic [GROUPS*IDX_W-1:0]  nxt_idx;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [GSIZE-1:0] hot;
      allpairs_max_group #(
         .GSIZE  (GSIZE),
         .DATA_W (DATA_W),
         .IDX_W  (IDX_W)
      ) u_grp (
         .grp_val (stg_in_val[g*GV_W +: GV_W]),
         .grp_idx (stg_in_idx[g*GI_W +: GI_W]),
         .win_val (nxt_val[g*DATA_W +: DATA_W]),
         .win_idx (nxt_idx[g*IDX_W +: IDX_W]),
         .win_hot (hot)
      );
   end

   // round register: winners land in fixed slots for the next round
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_out_valid <= 1'b0;
         stg_out_val   <= '0;
         stg_out_idx   <= '0;
      end else begin
         stg_out_valid <= stg_in_valid;
         if (stg_in_valid) begin
            stg_out_val <= nxt_val;
            stg_out_idx <= nxt_idx;
         end
      end
   end

endmodule

// File: rtl/allpairs_max.sv
module allpairs_max
   import allpairs_max_pkg::*;
#(
   parameter int N_IN   = 21,
   parameter int DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [N_IN*DATA_W-1:0] in_data,
   output logic                   out_valid,
   output logic [DATA_W-1:0]      out_max,
   output logic [$clog2(N_IN)-1:0] out_idx
);

   localparam int IDX_W = $clog2(N_IN);
   localparam int GS1   = grp_size(1);
   localparam int GS2   = grp_size(2);
   localparam int G1    = N_IN / GS1;

   if (DATA_W < 1) begin : g_bad_width
      $error("allpairs_max: DATA_W must be positive");
   end
   if ((N_IN % GS1) != 0) begin : g_bad_split
      $error("allpairs_max: N_IN must fill whole first-round groups");
   end
   if (G1 != GS2) begin : g_bad_rounds
      $error("allpairs_max: first-round winners must form one second-round group");
   end
   if (pair_count(GS2) != (GS2 * (GS2 - 1)) / 2) begin : g_bad_pairs
      $error("allpairs_max: comparator count mismatch");
   end

   // original positions travel with the values
   logic [N_IN*IDX_W-1:0] pos0;
   for (genvar i = 0; i < N_IN; i++) begin : g_pos
      assign pos0[i*IDX_W +: IDX_W] = IDX_W'(i);
   end

   logic                  r1_valid;
   logic [G1*DATA_W-1:0]  r1_val;
   logic [G1*IDX_W-1:0]   r1_idx;

   allpairs_max_round #(
      .GROUPS (G1),
      .GSIZE  (GS1),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_round1 (
      .clk           (clk),
      .rst_n         (rst_n),
      .stg_in_valid  (in_valid),
      .stg_in_val    (in_data),
      .stg_in_idx    (pos0),
      .stg_out_valid (r1_valid),
      .stg_out_val   (r1_val),
      .stg_out_idx   (r1_idx)
   );

   allpairs_max_round #(
      .GROUPS (1),
      .GSIZE  (GS2),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_round2 (
      .clk           (clk),
      .rst_n         (rst_n),
      .stg_in_valid  (r1_valid),
      .stg_in_val    (r1_val),
      .stg_in_idx    (r1_idx),
      .stg_out_valid (out_valid),
      .stg_out_val   (out_max),
      .stg_out_idx   (out_idx)
   );

endmodule

// File: rtl/allpairs_max_chk.sv
module allpairs_max_chk #(
   parameter int N_IN   = 21,
   parameter int DATA_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [N_IN*DATA_W-1:0]  in_data,
   input logic                    out_valid,
   input logic [DATA_W-1:0]       out_max,
   input logic [$clog2(N_IN)-1:0] out_idx
);

   localparam int IDX_W = $clog2(N_IN);

   logic [N_IN*DATA_W-1:0] d1, d2;
   logic                   v1, v2;
   logic [1:0]             since_rst;
   logic                   none_greater, idx_matches, no_lower_tie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d1        <= '0;
         d2        <= '0;
         v1        <= 1'b0;
         v2        <= 1'b0;
         since_rst <= '0;
      end else begin
         d1 <= in_data;
         d2 <= d1;
         v1 <= in_valid;
         v2 <= v1;
         if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      end
   end

   always_comb begin
      none_greater = 1'b1;
      idx_matches  = 1'b0;
      no_lower_tie = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
         if (d2[i*DATA_W +: DATA_W] > out_max) none_greater = 1'b0;
         if ((IDX_W'(i) == out_idx) && (d2[i*DATA_W +: DATA_W] == out_max)) idx_matches = 1'b1;
         if ((IDX_W'(i) < out_idx) && (d2[i*DATA_W +: DATA_W] == out_max)) no_lower_tie = 1'b0;
      end
   end

   // R1
   max_not_exceeded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> none_greater);

   // R2
   idx_points_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (idx_matches && (out_idx < IDX_W'(N_IN))));

   // R3
   lowest_tie_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> no_lower_tie);

   // R4
   valid_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v2);

   // R6
   quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 2'd2) |-> !out_valid);

endmodule

bind allpairs_max allpairs_max_chk #(
   .N_IN   (N_IN),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_max   (out_max),
   .out_idx   (out_idx)
);

// File: tb/allpairs_max_tb.sv
module allpairs_max_tb;

   localparam int N  = 21;
   localparam int DW = 16;
   localparam int IW = 5;

   typedef struct packed {
      logic [15:0] fill;
      logic [4:0]  pa;
      logic [15:0] va;
      logic [4:0]  pb;
      logic [15:0] vb;
      logic [15:0] emax;
      logic [4:0]  eidx;
      logic        tie;
   } vec_t;

   // fill all positions, then write va at pa, then vb at pb
   localparam vec_t TABLE [8] = '{
      '{16'h0000, 5'd0,  16'h0000, 5'd0,  16'h0000, 16'h0000, 5'd0,  1'b1},
      '{16'h0005, 5'd20, 16'h0064, 5'd0,  16'h0005, 16'h0064, 5'd20, 1'b0},
      '{16'h0001, 5'd3,  16'hFFFF, 5'd17, 16'hFFFF, 16'hFFFF, 5'd3,  1'b1},
      '{16'd1000, 5'd0,  16'd2000, 5'd10, 16'd1999, 16'd2000, 5'd0,  1'b0},
      '{16'hFFFF, 5'd9,  16'hFFFF, 5'd9,  16'hFFFF, 16'hFFFF, 5'd0,  1'b1},
      '{16'h0007, 5'd13, 16'h0008, 5'd14, 16'h0009, 16'h0009, 5'd14, 1'b0},
      '{16'd300,  5'd2,  16'd301,  5'd18, 16'd301,  16'd301,  5'd2,  1'b1},
      '{16'd300,  5'd5,  16'd400,  5'd4,  16'd400,  16'd400,  5'd4,  1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [N*DW-1:0]   in_data = '0;
   logic              out_valid;
   logic [DW-1:0]     out_max;
   logic [IW-1:0]     out_idx;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // expected pipeline: slot 0 driven one negedge ago, slot 1 two ago
   logic          pv0 = 0, pv1 = 0;
   logic [15:0]   pm0 = 0, pm1 = 0;
   logic [4:0]    pi0 = 0, pi1 = 0;
   logic          pt0 = 0, pt1 = 0;
   logic [31:0]   lfsr = 32'h1234_5678;

   always #2 clk = ~clk;

   allpairs_max #(.N_IN(N), .DATA_W(DW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_max   (out_max),
      .out_idx   (out_idx)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   function automatic void ref_max(input logic [N*DW-1:0] d, output logic [15:0] m,
                                   output logic [4:0] ix, output logic tie);
      int cnt;
      m = d[15:0];
      ix = 0;
      for (int i = 1; i < N; i++) begin
         if (d[i*DW +: DW] > m) begin
            m = d[i*DW +: DW];
            ix = 5'(i);
         end
      end
      cnt = 0;
      for (int i = 0; i < N; i++) if (d[i*DW +: DW] == m) cnt++;
      tie = (cnt > 1);
   endfunction

   task automatic step(input logic v, input logic [N*DW-1:0] d, input logic [15:0] em,
                       input logic [4:0] ei, input logic tie);
      @(negedge clk);
      chk(out_valid == pv1, "R4 out_valid", 32'(out_valid), 32'(pv1));
      if (pv1) begin
         chk(out_max == pm1, "R1 out_max", 32'(out_max), 32'(pm1));
         chk(out_idx == pi1, pt1 ? "R3 out_idx tie" : "R2 out_idx", 32'(out_idx), 32'(pi1));
      end
      pv1 = pv0; pm1 = pm0; pi1 = pi0; pt1 = pt0;
      pv0 = v;   pm0 = em;  pi0 = ei;  pt0 = tie;
      in_valid = v;
      in_data  = d;
   endtask

   task automatic rand_step(input logic v, input bit narrow);
      logic [N*DW-1:0] d;
      logic [15:0] m;
      logic [4:0]  ix;
      logic        t;
      for (int i = 0; i < N; i++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         d[i*DW +: DW] = narrow ? {12'h0, lfsr[3:0]} : lfsr[15:0];
      end
      ref_max(d, m, ix, t);
      step(v, d, m, ix, t);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [N*DW-1:0] d;
      // R6: quiet during reset
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R6 out_valid in reset", 32'(out_valid), 0);
      rst_n = 1'b1;

      // table walk, back to back
      foreach (TABLE[k]) begin
         for (int i = 0; i < N; i++) d[i*DW +: DW] = TABLE[k].fill;
         d[TABLE[k].pa*DW +: DW] = TABLE[k].va;
         d[TABLE[k].pb*DW +: DW] = TABLE[k].vb;
         step(1'b1, d, TABLE[k].emax, TABLE[k].eidx, TABLE[k].tie);
      end
      step(1'b0, '0, 0, 0, 0);
      step(1'b0, '0, 0, 0, 0);

      // R5: long back-to-back stream, wide and narrow (tie-heavy) values
      for (int k = 0; k < 150; k++) rand_step(1'b1, k[0]);
      // R4: gaps in the stream
      for (int k = 0; k < 80; k++) rand_step((k % 3) != 1, k[1]);
      step(1'b0, '0, 0, 0, 0);
      step(1'b0, '0, 0, 0, 0);

      // R6: reset while vectors are in flight
      rand_step(1'b1, 1'b0);
      rand_step(1'b1, 1'b0);
      #1 rst_n = 1'b0;
      #1 chk(out_valid == 1'b0, "R6 out_valid at reset", 32'(out_valid), 0);
      in_valid = 1'b0;
      pv0 = 0; pv1 = 0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R6 no result leaks past reset", 32'(out_valid), 0);
      end
      for (int k = 0; k < 10; k++) rand_step(1'b1, 1'b1);
      step(1'b0, '0, 0, 0, 0);
      step(1'b0, '0, 0, 0, 0);
      step(1'b0, '0, 0, 0, 0);
      finish_up();
   end

endmodule